// File: doc/BRIEF.md
# PIO Task-File Cycle Timing Generator

This block times one programmed-I/O access to a disk drive's task-file registers. The access is split into three phases, each counted in bus clocks. First comes an address phase, in which the address is valid and both strobes stay inactive. Next is the strobe phase, in which either the read strobe or the write strobe is driven low. Last is a recovery phase, in which both strobes are inactive again before the next access may begin.

Two drives share the cable. The address-phase length is common to both drives. It is taken as the longer of the two present drives' programmed setup values. The strobe and recovery lengths come from a field set that is chosen by the target drive and by the direction of the access, so read and write timings are independent.

A drive marked absent is timed at the shortest legal lengths, and its programmed setup value does not count toward the shared address phase. A requester raises `cyc_req` for one clock. A request that arrives while an access is in progress is remembered and started once the current access has finished. Drive and direction are captured at the start of each access.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, `busy` and `done` are 0, `addr_valid` is 0, and both `dior_n` and `diow_n` are 1.
- R2: An accepted access first holds `addr_valid`=1 with both strobes high for S clocks. S = 1 + the largest 2-bit `setup_code` among drives whose `drv_present` bit is 1, or S = 1 when no drive is present.
- R3: After the address phase, the strobe for the direction drives low for exactly P = `pulse_code`+1 clocks (1 to 16). The read strobe is `dior_n` when `cyc_write`=0, and the write strobe is `diow_n` when `cyc_write`=1. The other strobe stays high throughout, and `addr_valid` stays 1.
- R4: After the strobe phase, both strobes are high and `busy` stays 1 for R = `recov_code`+2 clocks (2 to 17).
- R5: Read accesses use `rd_pulse_code`/`rd_recov_code`, and write accesses use `wr_pulse_code`/`wr_recov_code`.
- R6: The drive selected by `drv_sel` (0 or 1) picks index 0 or 1 of each per-drive field.
- R7: When the selected drive's `drv_present` bit is 0, its fields are ignored. The strobe lasts 1 clock and recovery lasts 2 clocks, while the address phase still follows R2.
- R8: `done` is 1 for exactly one clock, the first clock after recovery, and `busy` is 0 in that clock.
- R9: A `cyc_req` raised while `busy` is 1 is held. The held access starts so that `busy` returns to 1 in the clock right after the `done` clock.
- R10: Changes to `drv_sel`, `cyc_write` or any timing field after an access has been accepted do not alter that access's phase lengths or its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_present | input | 2 | Per-drive presence flags |
| setup_code | input | 2x2 | Per-drive address-setup requirement, clocks minus 1 |
| rd_pulse_code | input | 2x4 | Per-drive read strobe length, clocks minus 1 |
| rd_recov_code | input | 2x4 | Per-drive read recovery length, clocks minus 2 |
| wr_pulse_code | input | 2x4 | Per-drive write strobe length, clocks minus 1 |
| wr_recov_code | input | 2x4 | Per-drive write recovery length, clocks minus 2 |
| cyc_req | input | 1 | Access request, one-clock pulse |
| cyc_write | input | 1 | Direction: 1 write, 0 read |
| drv_sel | input | 1 | Target drive |
| addr_valid | output | 1 | Address valid during the whole access |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |

## Verification
A phase counter loaded with the wrong length, or a phase that is skipped, shows up as a strobe edge at the wrong clock. It therefore appears as early as the access in which it happens, within at most 37 clocks. If the wrong direction or drive is latched, the wrong strobe falls or the strobe width changes in that same access. If a pending request is lost, `busy` fails to rise in the clock after `done`. If state leaks from one access into the next, the next access's phase counts are wrong.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } pio_phase_e;
endpackage

// File: rtl/pio_reset_sync.sv
module pio_reset_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select #(
  parameter int NDRV  = 2,
  parameter int SU_W  = 2,
  parameter int PW_W  = 4,
  parameter int RC_W  = 4,
  parameter int CNT_W = 5,
  localparam int DSW  = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic [NDRV-1:0]           present,
  input  logic [NDRV-1:0][SU_W-1:0] su_code,
  input  logic [NDRV-1:0][PW_W-1:0] rd_pw,
  input  logic [NDRV-1:0][RC_W-1:0] rd_rc,
  input  logic [NDRV-1:0][PW_W-1:0] wr_pw,
  input  logic [NDRV-1:0][RC_W-1:0] wr_rc,
  input  logic [DSW-1:0]            drv,
  input  logic                      is_write,
  output logic [CNT_W-1:0]          setup_m1,
  output logic [CNT_W-1:0]          pulse_m1,
  output logic [CNT_W-1:0]          recov_m1
);
  logic [SU_W-1:0] su_max;
  logic [PW_W-1:0] pw_sel;
  logic [RC_W-1:0] rc_sel;
  logic            drv_here;

  // Shared setup: longest requirement among present drives.
  always_comb begin
    su_max = '0;
    for (int d = 0; d < NDRV; d++) begin
      if (present[d] && (su_code[d] > su_max)) su_max = su_code[d];
    end
  end

  always_comb begin
    drv_here = present[drv];
    pw_sel   = is_write ? wr_pw[drv] : rd_pw[drv];
    rc_sel   = is_write ? wr_rc[drv] : rd_rc[drv];
  end

  // Absent drive falls back to the shortest lengths (codes of zero).
  assign setup_m1 = CNT_W'(su_max);
  assign pulse_m1 = drv_here ? CNT_W'(pw_sel) : '0;
  assign recov_m1 = drv_here ? (CNT_W'(rc_sel) + CNT_W'(1)) : CNT_W'(1);
endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
  import pio_timer_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SU_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             is_write,
  input  logic [CNT_W-1:0] setup_m1,
  input  logic [CNT_W-1:0] pulse_m1,
  input  logic [CNT_W-1:0] recov_m1,
  output pio_phase_e       phase,
  output logic             dir_wr,
  output logic             done
);
  localparam logic [CNT_W-1:0] SU_LIMIT = CNT_W'((1 << SU_W) - 1);

  pio_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pw_q, pw_d;
  logic [CNT_W-1:0] rc_q, rc_d;
  logic             dir_q, dir_d;
  logic             pend_q, pend_d;
  logic             done_q, done_d;
  logic             cnt_zero;
  logic             start;
  logic             cap_en;

  assign cnt_zero = (cnt_q == '0);
  assign start    = (phase_q == PH_IDLE) && (req || pend_q);
  assign cap_en   = start;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = setup_m1;
          pend_d  = 1'b0;
        end
      end
      PH_SETUP: begin
        if (req) pend_d = 1'b1;
        if (cnt_zero) begin
          phase_d = PH_ACTIVE;
          cnt_d   = pw_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (req) pend_d = 1'b1;
        if (cnt_zero) begin
          phase_d = PH_RECOV;
          cnt_d   = rc_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_RECOV: begin
        if (req) pend_d = 1'b1;
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Per-access capture: only loaded when a cycle starts.
  always_comb begin
    pw_d  = cap_en ? pulse_m1 : pw_q;
    rc_d  = cap_en ? recov_m1 : rc_q;
    dir_d = cap_en ? is_write : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pw_q    <= '0;
      rc_q    <= '0;
      dir_q   <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pw_q    <= pw_d;
      rc_q    <= rc_d;
      dir_q   <= dir_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  assign phase  = phase_q;
  assign dir_wr = dir_q;
  assign done   = done_q;

  // R2: the shared address phase never exceeds its field range.
  p_setup_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |-> (cnt_q <= SU_LIMIT));

  // R9: a request seen during a cycle is held until the cycle ends.
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (phase_q != PH_IDLE)) |=> pend_q || (phase_q == PH_SETUP));

  // R10: captured direction is stable for the whole access.
  p_dir_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q != PH_IDLE) && (phase_d != PH_IDLE) && !start) |=> $stable(dir_q));
endmodule

// File: rtl/pio_strobe_decode.sv
module pio_strobe_decode
  import pio_timer_pkg::*;
(
  input  pio_phase_e phase,
  input  logic       dir_wr,
  output logic       addr_valid,
  output logic       dior_n,
  output logic       diow_n,
  output logic       busy
);
  logic strobe_on;

  assign strobe_on  = (phase == PH_ACTIVE);
  assign busy       = (phase != PH_IDLE);
  assign addr_valid = busy;
  assign dior_n     = ~(strobe_on & ~dir_wr);
  assign diow_n     = ~(strobe_on &  dir_wr);
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter int NDRV = 2,
  parameter int SU_W = 2,
  parameter int PW_W = 4,
  parameter int RC_W = 4,
  localparam int DSW = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NDRV-1:0]           drv_present,
  input  logic [NDRV-1:0][SU_W-1:0] setup_code,
  input  logic [NDRV-1:0][PW_W-1:0] rd_pulse_code,
  input  logic [NDRV-1:0][RC_W-1:0] rd_recov_code,
  input  logic [NDRV-1:0][PW_W-1:0] wr_pulse_code,
  input  logic [NDRV-1:0][RC_W-1:0] wr_recov_code,
  input  logic                      cyc_req,
  input  logic                      cyc_write,
  input  logic [DSW-1:0]            drv_sel,
  output logic                      addr_valid,
  output logic                      dior_n,
  output logic                      diow_n,
  output logic                      busy,
  output logic                      done
);
  localparam int CNT_W = ((PW_W > RC_W) ? PW_W : RC_W) + 1;

  logic             rst_int_n;
  logic [CNT_W-1:0] setup_m1, pulse_m1, recov_m1;
  pio_phase_e       phase;
  logic             dir_wr;

  pio_reset_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  pio_timing_select #(
    .NDRV (NDRV), .SU_W (SU_W), .PW_W (PW_W), .RC_W (RC_W), .CNT_W (CNT_W)
  ) u_sel (
    .present  (drv_present),
    .su_code  (setup_code),
    .rd_pw    (rd_pulse_code),
    .rd_rc    (rd_recov_code),
    .wr_pw    (wr_pulse_code),
    .wr_rc    (wr_recov_code),
    .drv      (drv_sel),
    .is_write (cyc_write),
    .setup_m1 (setup_m1),
    .pulse_m1 (pulse_m1),
    .recov_m1 (recov_m1)
  );

  pio_phase_fsm #(.CNT_W (CNT_W), .SU_W (SU_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (cyc_req),
    .is_write (cyc_write),
    .setup_m1 (setup_m1),
    .pulse_m1 (pulse_m1),
    .recov_m1 (recov_m1),
    .phase    (phase),
    .dir_wr   (dir_wr),
    .done     (done)
  );

  pio_strobe_decode u_dec (
    .phase      (phase),
    .dir_wr     (dir_wr),
    .addr_valid (addr_valid),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .busy       (busy)
  );

  // R3: the two strobes are never active together.
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(!dior_n && !diow_n));

  // R3: a strobe only falls while the address is valid.
  p_strobe_addr_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!dior_n || !diow_n) |-> addr_valid);

  // R8: done lasts a single clock and never overlaps an access.
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);

  // R8: every end of an access is marked by done.
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(busy) |-> done);
endmodule

// File: tb/pio_cycle_timer_bench.sv
`timescale 1ns/1ps
module pio_cycle_timer_bench;
  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      pres;
  logic [1:0][1:0] su;
  logic [1:0][3:0] rdp, rdr, wrp, wrr;
  logic            req, wr, drv;
  logic            addr_valid, dior_n, diow_n, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  pio_cycle_timer u_pio_cycle_timer (
    .clk (clk), .rst_n (rst_n), .drv_present (pres), .setup_code (su),
    .rd_pulse_code (rdp), .rd_recov_code (rdr),
    .wr_pulse_code (wrp), .wr_recov_code (wrr),
    .cyc_req (req), .cyc_write (wr), .drv_sel (drv),
    .addr_valid (addr_valid), .dior_n (dior_n), .diow_n (diow_n),
    .busy (busy), .done (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_setup();
    int m = 0;
    for (int d = 0; d < 2; d++) if (pres[d] && int'(su[d]) > m) m = int'(su[d]);
    return m + 1;
  endfunction

  function automatic int exp_pulse(input bit d, input bit w);
    if (!pres[d]) return 1;
    return (w ? int'(wrp[d]) : int'(rdp[d])) + 1;
  endfunction

  function automatic int exp_recov(input bit d, input bit w);
    if (!pres[d]) return 2;
    return (w ? int'(wrr[d]) : int'(rdr[d])) + 2;
  endfunction

  // Called at the negedge where the first busy clock is visible.
  task automatic measure(input int es, input int ep, input int er, input bit w,
                         input string tag, input bit hold, input bit nd,
                         input bit nw, input bit perturb);
    int s = 0, p = 0, r = 0, ph = 0;
    bit fin = 0;
    check(busy == 1'b1, "R9 access started", int'(busy), 1);
    for (int k = 0; k < 80 && !fin; k++) begin
      if (ph == 0) begin
        if (busy && dior_n && diow_n) begin
          s++;
          check(addr_valid == 1'b1, "R2 addr_valid in setup", int'(addr_valid), 1);
        end else ph = 1;
      end
      if (ph == 1) begin
        if (w ? !diow_n : !dior_n) begin
          p++;
          check((w ? dior_n : diow_n) == 1'b1, "R3 other strobe high",
                int'(w ? dior_n : diow_n), 1);
          check(addr_valid == 1'b1, "R3 addr_valid in strobe", int'(addr_valid), 1);
        end else ph = 2;
      end
      if (ph == 2) begin
        if (busy) begin
          r++;
          check(dior_n && diow_n, "R4 strobes high in recovery", int'(dior_n & diow_n), 1);
        end else fin = 1;
      end
      if (!fin) begin
        if (k == 0) begin
          req = hold;
          drv = nd;
          wr  = nw;
          if (perturb) begin
            su = ~su; rdp = ~rdp; rdr = ~rdr; wrp = ~wrp; wrr = ~wrr;
          end
        end else if (k == 1) begin
          req = 1'b0;
        end
        @(negedge clk);
      end
    end
    check(s == es, {"R2 R10 setup length ", tag}, s, es);
    check(p == ep, {"R3 R10 strobe length ", tag}, p, ep);
    check(r == er, {"R4 R10 recovery length ", tag}, r, er);
    check(done == 1'b1, "R8 done after recovery", int'(done), 1);
    check(busy == 1'b0, "R8 idle during done", int'(busy), 0);
  endtask

  task automatic set_cfg(input int c, input logic [1:0] pr);
    pres   = pr;
    su[0]  = 2'(c % 4);
    su[1]  = 2'((c / 4) % 4);
    rdp[0] = 4'(c);
    rdp[1] = 4'(c ^ 5);
    wrp[0] = 4'(15 - c);
    wrp[1] = 4'((15 - c) ^ 9);
    rdr[0] = 4'((c + 3) % 16);
    rdr[1] = 4'((c + 11) % 16);
    wrr[0] = 4'((c * 7) % 16);
    wrr[1] = 4'((c * 5 + 2) % 16);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog expired", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = 1'b0; wr = 1'b0; drv = 1'b0;
    set_cfg(0, 2'b11);
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'({busy, done}), 0);
    check(addr_valid == 1'b0, "R1 reset addr_valid", int'(addr_valid), 0);
    check(dior_n && diow_n, "R1 reset strobes", int'({dior_n, diow_n}), 3);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && dior_n && diow_n, "R1 idle after reset",
          int'({busy, dior_n, diow_n}), 3);

    // Sweep: presence x drive x direction x field pattern.
    for (int pr = 0; pr < 4; pr++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w2 = 0; w2 < 2; w2++) begin
          for (int c = 0; c < 16; c++) begin
            int es, ep, er;
            string tag;
            set_cfg(c, 2'(pr));
            drv = d[0]; wr = w2[0];
            es = exp_setup();
            ep = exp_pulse(d[0], w2[0]);
            er = exp_recov(d[0], w2[0]);
            tag = pres[d] ? "R5 R6" : "R7";
            req = 1'b1;
            @(negedge clk);
            measure(es, ep, er, w2[0], tag, 1'b0, ~d[0], ~w2[0], 1'b1);
            @(negedge clk);
            check(done == 1'b0 && busy == 1'b0, "R8 done single clock",
                  int'({done, busy}), 0);
          end
        end
      end
    end

    // Held request: second access follows the done clock directly.
    for (int c = 0; c < 8; c++) begin
      bit d1, w1, d2, w2b;
      int es, ep1, er1, ep2, er2;
      set_cfg(c * 2 + 1, 2'b11);
      d1 = c[0]; w1 = c[1]; d2 = ~c[0]; w2b = c[2];
      es  = exp_setup();
      ep1 = exp_pulse(d1, w1);  er1 = exp_recov(d1, w1);
      ep2 = exp_pulse(d2, w2b); er2 = exp_recov(d2, w2b);
      drv = d1; wr = w1; req = 1'b1;
      @(negedge clk);
      measure(es, ep1, er1, w1, "R9 first", 1'b1, d2, w2b, 1'b0);
      @(negedge clk);
      measure(es, ep2, er2, w2b, "R9 held", 1'b0, d2, w2b, 1'b0);
      @(negedge clk);
      check(busy == 1'b0, "R9 no extra access", int'(busy), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule